// File: doc/BRIEF.md
# Encoded Bidirectional Accumulator Shifter

This combinational block shifts an accumulator value by a count and in a direction both taken from a small control word. That word lives in an operand field that the doubling instruction does not otherwise use. An all-zero word gives one left shift, which is the same result as adding the accumulator to itself. Existing code that leaves the field at zero therefore keeps working. A non-zero word selects any shift from one to fifteen places, either left or right.

A mode input selects the width. In 8-bit mode the block uses only the low byte, and results that shift past eight places come out as zero. In 16-bit mode the block shifts the full 16-bit word by up to fifteen places. A carry output reports the last bit that left the active width.

Top module: `acc_shifter`

## Requirements
- R1: A control word of 0 shifts left by one place. In 8-bit mode, {shift_cout, shift_out[7:0]} equals the low input byte added to itself.
- R2: Control bit [4] selects the direction: 0 shifts toward the MSB (left) and 1 shifts toward the LSB (right).
- R3: Control bits [3:0] give the count. A value of 0 means one place, and values 1 to 15 mean that many places.
- R4: Every shift is logical. Left shifts fill the low end with zeros, and right shifts fill the high end with zeros.
- R5: When wide_mode is 0, acc_in[15:8] has no effect and shift_out[15:8] is 0.
- R6: In 8-bit mode, a count of 8 gives shift_out = 0. shift_cout is then acc_in[0] for a left shift and acc_in[7] for a right shift.
- R7: In 8-bit mode, a count above 8 gives shift_out = 0 and shift_cout = 0.
- R8: When wide_mode is 1, the block shifts all 16 bits by 1 to 15 places. shift_cout is acc_in[16-n] for a left shift and acc_in[n-1] for a right shift.
- R9: In 8-bit mode with a count n from 1 to 7, shift_cout is acc_in[8-n] for a left shift and acc_in[n-1] for a right shift.
- R10: A shift never creates set bits: the ones in shift_out plus shift_cout never exceed the ones in the active input width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_in | input | 16 | Accumulator value; only [7:0] is used in 8-bit mode |
| shift_ctl | input | 5 | Bit 4 is the direction (1 = right); bits 3:0 are the count code (0 means 1) |
| wide_mode | input | 1 | 1 selects 16-bit shifting, 0 selects 8-bit |
| shift_out | output | 16 | Shifted value |
| shift_cout | output | 1 | Last bit shifted out of the active width; 0 when the count exceeds it |

## Verification
Immediate assertions check four things on every input change:
- the zero-code doubling identity;
- the clean upper byte in 8-bit mode;
- the all-zero result past eight places;
- the rule that a shift never adds set bits.

The exact bit placement of each count and direction cannot be stated compactly as a property. The same holds for the carry position at the count-of-eight boundary and in 16-bit mode. These are shown only by the bench. It sweeps every control code in both modes over several data patterns, including patterns with junk in the ignored upper byte.

// File: rtl/acc_shifter.sv
module acc_shifter #(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic [DATA_W-1:0]            acc_in,
  input  logic [$clog2(DATA_W):0]      shift_ctl,
  input  logic                         wide_mode,
  output logic [DATA_W-1:0]            shift_out,
  output logic                         shift_cout
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam int EXT_W = DATA_W + 1;
  localparam int PAD_W = DATA_W - NARROW_W;

  logic [CNT_W-1:0] amt;
  logic             go_right;
  logic [DATA_W-1:0] src;
  logic [EXT_W-1:0] ext_l, ext_r;

  assign go_right = shift_ctl[CNT_W];
  assign amt      = (shift_ctl[CNT_W-1:0] == '0) ? CNT_W'(1) : shift_ctl[CNT_W-1:0];
  assign src      = wide_mode ? acc_in : {{PAD_W{1'b0}}, acc_in[NARROW_W-1:0]};
  assign ext_l    = {1'b0, src} << amt;
  assign ext_r    = {src, 1'b0} >> amt;

  always_comb begin
    if (go_right) begin
      shift_out  = ext_r[EXT_W-1:1];
      shift_cout = ext_r[0];
    end else if (wide_mode) begin
      shift_out  = ext_l[DATA_W-1:0];
      shift_cout = ext_l[DATA_W];
    end else begin
      shift_out  = {{PAD_W{1'b0}}, ext_l[NARROW_W-1:0]};
      shift_cout = ext_l[NARROW_W];
    end
  end

  always_comb begin
    if (!$isunknown({acc_in, shift_ctl, wide_mode})) begin
      if (!wide_mode && shift_ctl == '0)
        p_zero_code_doubles_r1: assert ({shift_cout, shift_out[NARROW_W-1:0]} ==
                                        {1'b0, acc_in[NARROW_W-1:0]} + {1'b0, acc_in[NARROW_W-1:0]})
          else $error("zero code is not a doubling");
      if (!wide_mode)
        p_upper_clear_r5: assert (shift_out[DATA_W-1:NARROW_W] == '0)
          else $error("upper byte leaked in 8-bit mode");
      if (!wide_mode && shift_ctl[CNT_W-1:0] > NARROW_W)
        p_overrun_zero_r7: assert (shift_out == '0 && !shift_cout)
          else $error("overrun shift left bits behind");
      p_no_new_ones_r10: assert ($countones(shift_out) + $countones(shift_cout) <=
                                 $countones(src))
        else $error("shift created set bits");
    end
  end
endmodule

// File: tb/tb_acc_shifter.sv
module tb_acc_shifter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [15:0] acc_in = '0;
  logic [4:0]  shift_ctl = '0;
  logic        wide_mode = 1'b0;
  logic [15:0] shift_out;
  logic        shift_cout;
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  acc_shifter dut (
    .acc_in(acc_in), .shift_ctl(shift_ctl), .wide_mode(wide_mode),
    .shift_out(shift_out), .shift_cout(shift_cout)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [16:0] model(input logic [15:0] d, input logic [4:0] c, input logic w);
    int n, width;
    logic [15:0] r;
    logic cy;
    n = (c[3:0] == 0) ? 1 : int'(c[3:0]);
    width = w ? 16 : 8;
    r = '0;
    cy = 1'b0;
    for (int i = 0; i < width; i++) begin
      if (!c[4]) begin
        if (i - n >= 0) r[i] = d[i-n];
      end else begin
        if (i + n < width) r[i] = d[i+n];
      end
    end
    if (!c[4]) begin
      if (width - n >= 0) cy = d[width-n];
    end else begin
      if (n - 1 < width) cy = d[n-1];
    end
    return {cy, r};
  endfunction

  function automatic string tag_of(input logic [4:0] c, input logic w);
    int n;
    n = (c[3:0] == 0) ? 1 : int'(c[3:0]);
    if (c == 5'd0) return "R1";
    if (w) return "R8";
    if (n > 8) return "R7";
    if (n == 8) return "R6";
    return "R9";
  endfunction

  task automatic check(input logic [15:0] d, input logic [4:0] c, input logic w, input string tag);
    logic [16:0] exp;
    @(posedge clk);
    acc_in = d; shift_ctl = c; wide_mode = w;
    @(negedge clk);
    exp = model(d, c, w);
    compared++;
    if ({shift_cout, shift_out} !== exp) begin
      mismatched++;
      $display("FAIL %s: d=%h ctl=%h wide=%0d got cout=%b out=%h exp cout=%b out=%h",
               tag, d, c, w, shift_cout, shift_out, exp[16], exp[15:0]);
    end
  endtask

  initial begin
    logic [15:0] pats [8];
    pats = '{16'h0000, 16'hFFFF, 16'h00A5, 16'hA55A, 16'h8001, 16'h7F80, 16'h1234, 16'hC3E7};
    check(16'h0000, 5'd0, 1'b0, "R1");
    check(16'h0081, 5'd0, 1'b0, "R1");
    check(16'h0081, 5'h01, 1'b0, "R2");
    check(16'h0081, 5'h11, 1'b0, "R2");
    check(16'h00FF, 5'h03, 1'b0, "R3");
    check(16'h00FF, 5'h13, 1'b0, "R4");
    check(16'hFFFF, 5'h1F, 1'b1, "R4");
    check(16'hAB3C, 5'h02, 1'b0, "R5");
    check(16'hFF00, 5'h11, 1'b0, "R5");
    check(16'h0081, 5'h08, 1'b0, "R6");
    check(16'h0081, 5'h18, 1'b0, "R6");
    check(16'h00FF, 5'h09, 1'b0, "R7");
    check(16'h00FF, 5'h1F, 1'b0, "R7");
    check(16'h8001, 5'h0F, 1'b1, "R8");
    check(16'h8001, 5'h1F, 1'b1, "R8");
    check(16'h0040, 5'h02, 1'b0, "R9");
    check(16'h00F0, 5'h1B, 1'b1, "R10");
    for (int w = 0; w < 2; w++)
      for (int c = 0; c < 32; c++)
        for (int p = 0; p < 8; p++)
          check(pats[p], 5'(c), 1'(w), tag_of(5'(c), 1'(w)));
    for (int k = 0; k < 400; k++) begin
      logic [4:0] c;
      logic w;
      c = 5'($urandom);
      w = 1'($urandom);
      check(16'($urandom), c, w, tag_of(c, w));
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule